// File: doc/BRIEF.md
# Left-Aligned Pulse-Width Modulator with Compare Exchange

This block generates a left-aligned pulse train from an up-counter. Each period starts at count 0 with the output high. The output drops once the count reaches the active compare value. The counter then runs on to the active period value and wraps.

Two staging registers, one for the compare value and one for the period value, are loaded through a one-word write port. These values never touch a running period. At terminal count the staged period is promoted. When exchange mode is on, the active and staged compare values trade places.

A one-clock compare pulse marks the cycle in which the count equals the active compare value, so a DMA engine can use it to stage the next value.

Top module: `lapwm_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter and all four value registers (active and staged compare, active and staged period) are cleared. After reset with `en` high, `tc_pulse` is therefore high in every cycle and `pwm_out` stays low until a staged value is promoted.
- R2: With `en` high, the counter steps up by one per clock from 0 to the active period. `tc_pulse` is high during the cycle in which the count equals the active period, and the count is 0 in the next cycle.
- R3: `pwm_out` is high while `en` is high and the count is below the active compare value, and low otherwise. A compare value of 0 gives a constant low output. A compare value above the period gives a constant high output.
- R4: `cmp_pulse` is high for exactly the cycle in which `en` is high and the count equals the active compare value.
- R5: A write with `wr_sel` = 0 loads `wr_data` into the staged compare register only. The output keeps following the old active compare value until the next terminal count.
- R6: With `swap_en` high at a terminal count, the active compare register takes the staged value and the staged register takes the old active value.
- R7: A write with `wr_sel` = 1 loads the staged period register. The active period takes the staged value at every terminal count, whatever `swap_en` is.
- R8: With `swap_en` low at a terminal count, both compare registers keep their values.
- R9: When a staged-compare write coincides with a swapping terminal count, the active register takes the value staged before the write, and the staged register ends up holding the written value.
- R10: While `en` is low, the counter is held at 0 and all three outputs are low. Counting resumes from 0 in the cycle after `en` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Synchronous count enable |
| swap_en | input | 1 | Exchange compare registers at terminal count |
| wr_valid | input | 1 | Write strobe for a staged register |
| wr_sel | input | 1 | 0 selects staged compare, 1 selects staged period |
| wr_data | input | W | Value written to the selected staged register |
| pwm_out | output | 1 | Left-aligned pulse output |
| tc_pulse | output | 1 | High in the cycle the count equals the period |
| cmp_pulse | output | 1 | High in the cycle the count equals the compare value |

## Verification
All three outputs are decoded without registers from the counter, the active registers and `en`. Each output therefore reflects the current count in the same cycle, and a change to `en` shows up at once.

A write or a terminal count changes the registers at the next rising edge, so its effect is visible one cycle later. The bench drives inputs on the falling edge and samples 1 ns later. It steps a reference model at that same point, so that each expectation covers exactly one register update.

// File: rtl/lapwm_pkg.sv
// Shared types for the left-aligned PWM.
// Assumes a single write port that selects one of two staged registers.
package lapwm_pkg;
    typedef enum logic {
        SEL_CMP = 1'b0,
        SEL_PER = 1'b1
    } lapwm_sel_e;
endpackage

// File: rtl/lapwm_counter.sv
// Period counter: counts 0..per_act while enabled and flags the terminal count.
// Assumes per_act changes only on the edge that ends a terminal-count cycle.
module lapwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] per_act,
    output logic [W-1:0] cnt,
    output logic         tc
);
    // terminal count: last cycle of the period
    assign tc = en && (cnt == per_act);

    // count up, wrap at terminal count, hold at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tc) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lapwm_regs.sv
// Active and staged compare/period registers with exchange on terminal count.
// Assumes wr_valid is a single-cycle strobe; a write coinciding with tc lands after the exchange.
module lapwm_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tc,
    input  logic         swap_en,
    input  logic         wr_valid,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cmp_act,
    output logic [W-1:0] cmp_buf,
    output logic [W-1:0] per_act,
    output logic [W-1:0] per_buf
);
    import lapwm_pkg::*;

    lapwm_sel_e sel;
    logic       wr_cmp;
    logic       wr_per;
    logic       do_swap;

    assign sel     = lapwm_sel_e'(wr_sel);
    assign wr_cmp  = wr_valid && (sel == SEL_CMP);
    assign wr_per  = wr_valid && (sel == SEL_PER);
    assign do_swap = tc && swap_en;

    // staged period: loaded by software writes only
    always_ff @(posedge clk) begin
        if (!rst_n)      per_buf <= '0;
        else if (wr_per) per_buf <= wr_data;
    end

    // active period: promoted at every terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)  per_act <= '0;
        else if (tc) per_act <= per_buf;
    end

    // active compare: takes the staged value on a swapping terminal count
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_act <= '0;
        else if (do_swap) cmp_act <= cmp_buf;
    end

    // staged compare: a write wins over the exchange path
    always_ff @(posedge clk) begin
        if (!rst_n)       cmp_buf <= '0;
        else if (wr_cmp)  cmp_buf <= wr_data;
        else if (do_swap) cmp_buf <= cmp_act;
    end
endmodule

// File: rtl/lapwm_output.sv
// Output decode: left-aligned level and compare-match pulse from the live count.
// Assumes cnt is held at zero while disabled; outputs are forced low when en is low.
module lapwm_output #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_act,
    output logic         pwm_out,
    output logic         cmp_pulse
);
    // level is high from the start of the period until the compare point
    assign pwm_out   = en && (cnt < cmp_act);
    // single-cycle marker at the compare point
    assign cmp_pulse = en && (cnt == cmp_act);
endmodule

// File: rtl/lapwm_top.sv
// Left-aligned PWM top: counter, staged registers with exchange, output decode.
// Assumes a synchronous active-low reset and software writes through wr_* only.
module lapwm_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         swap_en,
    input  logic         wr_valid,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         pwm_out,
    output logic         tc_pulse,
    output logic         cmp_pulse
);
    logic [W-1:0] cnt;
    logic [W-1:0] cmp_act;
    logic [W-1:0] cmp_buf;
    logic [W-1:0] per_act;
    logic [W-1:0] per_buf;
    logic         tc;

    lapwm_counter #(.W(W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .per_act (per_act),
        .cnt     (cnt),
        .tc      (tc)
    );

    lapwm_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc       (tc),
        .swap_en  (swap_en),
        .wr_valid (wr_valid),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .cmp_act  (cmp_act),
        .cmp_buf  (cmp_buf),
        .per_act  (per_act),
        .per_buf  (per_buf)
    );

    lapwm_output #(.W(W)) u_output (
        .en        (en),
        .cnt       (cnt),
        .cmp_act   (cmp_act),
        .pwm_out   (pwm_out),
        .cmp_pulse (cmp_pulse)
    );

    assign tc_pulse = tc;
endmodule

// File: rtl/lapwm_checks.sv
// Protocol checks for lapwm_top, attached by bind.
// Assumes it observes the internal counter and registers of the top module.
module lapwm_checks #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         swap_en,
    input logic         tc_pulse,
    input logic         pwm_out,
    input logic         cmp_pulse,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp_act,
    input logic [W-1:0] cmp_buf,
    input logic [W-1:0] per_act,
    input logic [W-1:0] per_buf
);
    assert_wrap_after_tc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> (cnt == '0));

    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tc_pulse) |=> (cnt == $past(cnt) + 1'b1));

    assert_pulse_not_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pulse |-> !pwm_out);

    assert_hold_midperiod_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_pulse |=> ($stable(cmp_act) && $stable(per_act)));

    assert_swap_takes_buf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && swap_en) |=> (cmp_act == $past(cmp_buf)));

    assert_period_promote_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> (per_act == $past(per_buf)));

    assert_no_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !swap_en) |=> $stable(cmp_act));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
endmodule

bind lapwm_top lapwm_checks #(.W(W)) u_lapwm_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .swap_en   (swap_en),
    .tc_pulse  (tc_pulse),
    .pwm_out   (pwm_out),
    .cmp_pulse (cmp_pulse),
    .cnt       (cnt),
    .cmp_act   (cmp_act),
    .cmp_buf   (cmp_buf),
    .per_act   (per_act),
    .per_buf   (per_buf)
);

// File: tb/lapwm_top_bench.sv
`timescale 1ns/1ps
module lapwm_top_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         swap_en = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_out;
    logic         tc_pulse;
    logic         cmp_pulse;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference state, derived from the requirements
    int m_cnt = 0, m_ca = 0, m_cb = 0, m_pa = 0, m_pb = 0;

    always #2 clk = ~clk;

    lapwm_top #(.W(W)) u_lapwm_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .swap_en   (swap_en),
        .wr_valid  (wr_valid),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pwm_out   (pwm_out),
        .tc_pulse  (tc_pulse),
        .cmp_pulse (cmp_pulse)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %b expected %b (t=%0t)", req, what, got, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, check outputs, advance the model, wait for the edge
    task automatic step(input string tag, input logic e, input logic s,
                        input logic wv, input logic ws, input int wd);
        logic exp_tc, exp_pwm, exp_cmp;
        int   n_ca, n_cb;
        en = e; swap_en = s; wr_valid = wv; wr_sel = ws; wr_data = wd[W-1:0];
        #1;
        exp_tc  = e && (m_cnt == m_pa);
        exp_pwm = e && (m_cnt < m_ca);
        exp_cmp = e && (m_cnt == m_ca);
        chk({tag, "/R2"}, "tc_pulse",  tc_pulse,  exp_tc);
        chk({tag, "/R3"}, "pwm_out",   pwm_out,   exp_pwm);
        chk({tag, "/R4"}, "cmp_pulse", cmp_pulse, exp_cmp);
        n_ca = m_ca; n_cb = m_cb;
        if (exp_tc && s) begin n_ca = m_cb; n_cb = m_ca; end
        if (wv && !ws) n_cb = wd;
        if (exp_tc) m_pa = m_pb;
        if (wv && ws) m_pb = wd;
        m_ca = n_ca; m_cb = n_cb;
        m_cnt = (!e || exp_tc) ? 0 : m_cnt + 1;
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input logic s, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b1, s, 1'b0, 1'b0, 0);
    endtask

    // advance to the cycle where the model reaches terminal count
    task automatic to_tc(input string tag, input logic s);
        for (int i = 0; i < 300 && m_cnt != m_pa; i++) step(tag, 1'b1, s, 1'b0, 1'b0, 0);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++; tests++;
                $display("FAIL watchdog expired got %0d cycles expected fewer", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "pwm_out in reset",   pwm_out,   1'b0);
        chk("R1", "tc_pulse in reset",  tc_pulse,  1'b0);
        chk("R1", "cmp_pulse in reset", cmp_pulse, 1'b0);
        rst_n = 1'b1;
        // R10: disabled holds outputs low
        for (int i = 0; i < 3; i++) step("R10_idle", 1'b0, 1'b0, 1'b0, 1'b0, 0);
        // R1: registers zero -> tc every cycle, output low
        idle("R1_zero", 1'b0, 4);

        // R3/R6/R7: sweep period and compare with exchange on
        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 8; c++) begin
                step("R7_wrper", 1'b1, 1'b1, 1'b1, 1'b1, p);
                step("R6_wrcmp", 1'b1, 1'b1, 1'b1, 1'b0, c);
                idle("R6_sweep", 1'b1, 2 * (p + 1) + 3);
            end
        end

        // R5: staged write mid-period leaves current period alone
        step("R7_per9", 1'b1, 1'b1, 1'b1, 1'b1, 9);
        to_tc("R5_align", 1'b1);
        idle("R5_align", 1'b1, 3);
        step("R5_midwr", 1'b1, 1'b1, 1'b1, 1'b0, 2);
        idle("R5_hold", 1'b1, 25);

        // R8: exchange disabled keeps compare, period still promoted
        step("R8_wrcmp", 1'b1, 1'b0, 1'b1, 1'b0, 7);
        step("R8_wrper", 1'b1, 1'b0, 1'b1, 1'b1, 4);
        idle("R8_noswap", 1'b0, 30);

        // R9: compare write exactly at a swapping terminal count
        to_tc("R9_align", 1'b1);
        step("R9_coincide", 1'b1, 1'b1, 1'b1, 1'b0, 1);
        idle("R9_after", 1'b1, 20);
        to_tc("R9_align2", 1'b1);
        step("R9_coincide2", 1'b1, 1'b1, 1'b1, 1'b0, 6);
        idle("R9_after2", 1'b1, 20);

        // R10: drop enable mid-period, then resume from zero
        idle("R10_run", 1'b1, 2);
        for (int i = 0; i < 4; i++) step("R10_off", 1'b0, 1'b1, 1'b0, 1'b0, 0);
        idle("R10_resume", 1'b1, 20);

        // R3: compare above period gives constant high
        step("R3_big", 1'b1, 1'b1, 1'b1, 1'b0, 200);
        idle("R3_big", 1'b1, 30);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule